// File: doc/BRIEF.md
# Iterative AES Block Encryptor with Run-Time Key Length

This block performs the AES forward cipher on one 128-bit block. The key can be 128, 192 or 256 bits long. A two-bit select code, sampled when a block starts, sets the key length and with it the number of rounds: 10, 12 or 14. Software or a neighbouring controller first writes the key one 32-bit word at a time into an eight-slot key store. It then presents a plaintext block with a one-cycle start strobe. The block runs one cipher round per clock and expands the round keys on the fly from a sliding window of key-schedule words. When the last round completes, it raises a one-cycle done strobe and presents the ciphertext.

A single datapath serves all three key lengths. The schedule step produces four new schedule words every cycle. Its rotate/substitute/round-constant cadence and its feedback tap follow the word count of the selected key. Round zero, the plain XOR of the input block with the first four key words, is folded into the cycle that captures the input.

Top module: `aes_ks_core`

## Requirements
- R1: With key select 0, the key is the four words in slots 0..3. The block performs 10 rounds, and the result equals the standard AES-128 ciphertext.
- R2: With key select 1, the key is the six words in slots 0..5. The block performs 12 rounds, and the result equals the standard AES-192 ciphertext.
- R3: With key select 2, the key is the eight words in slots 0..7. The block performs 14 rounds, and the result equals the standard AES-256 ciphertext.
- R4: Key select 3 behaves exactly like key select 0: 128-bit key and 10 rounds.
- R5: A clock edge with key_load_i high writes key_word_i into slot key_idx_i. Slot 0 holds the most significant 32 bits of the key, which are its first four bytes, and later slots follow in key byte order. Byte 0 of each block is bits 127:120.
- R6: done_o is high for exactly one cycle. That cycle starts Nr clock edges after the edge that samples start_i, where Nr is 10, 12 or 14 for the selected key length.
- R7: A start_i pulse while a block is in flight is ignored. The running block keeps its result and its timing, and no extra done follows.
- R8: Key select and the key slots are sampled at the accepted start. Writes to the key store and changes to key select during a block leave that block's result unchanged.
- R9: data_o holds the last ciphertext, unchanged, until the next block completes.
- R10: After reset, done_o is low and data_o is zero.
- R11: A start_i raised during the done cycle is accepted. The next block then completes with the normal latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_sel_i | input | 2 | Key length code: 0 = 128, 1 = 192, 2 = 256, 3 = 128 |
| key_word_i | input | 32 | Key word to write |
| key_idx_i | input | 3 | Key store slot to write |
| key_load_i | input | 1 | Write strobe for the key store |
| data_i | input | 128 | Plaintext block |
| start_i | input | 1 | Start strobe, one cycle |
| data_o | output | 128 | Ciphertext of the last completed block |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The bench checks published vectors for each key length. A schedule tap or round-constant slip in the 192-bit case, where four words per cycle cross the six-word period, would corrupt only that key length's ciphertext. A missing extra substitution for 256-bit keys would break only the 256-bit vectors. A select code of 3 decoded as a 192- or 256-bit key would give the wrong ciphertext and a latency of 12 or 14. A start pulse mid-block that restarts the engine would show up as a later done and a different result. Key store writes and select changes made during a block would alter the result if the configuration were read live instead of latched. The bench also starts a block back to back in the done cycle, so a busy flag that clears one cycle late would drop that block.

// File: rtl/aes_ks_pkg.sv
`timescale 1ns/1ps
package aes_ks_pkg;

   localparam int BYTE_W = 8;

   function automatic logic [7:0] xt(input logic [7:0] b);
      return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] sh;
      acc = 8'h00;
      sh  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = xt(sh);
      end
      return acc;
   endfunction

   // substitution byte: multiplicative inverse (x^254) then affine map
   function automatic logic [7:0] sbox(input logic [7:0] b);
      logic [7:0] inv;
      logic [7:0] pw;
      inv = 8'h01;
      pw  = b;
      for (int k = 0; k < 8; k++) begin
         if (k != 0) inv = gmul(inv, pw);
         pw = gmul(pw, pw);
      end
      return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                 ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
   endfunction

   function automatic logic [31:0] sub_word(input logic [31:0] w);
      return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
   endfunction

   function automatic logic [31:0] rot_word(input logic [31:0] w);
      return {w[23:0], w[31:24]};
   endfunction

endpackage

// File: rtl/aes_ks_round.sv
`timescale 1ns/1ps
module aes_ks_round
   import aes_ks_pkg::*;
#(
   parameter int BLK_W = 128
) (
   input  logic [BLK_W-1:0] state_i,
   input  logic [BLK_W-1:0] rkey_i,
   input  logic             last_i,
   output logic [BLK_W-1:0] state_o
);

   localparam int NB = BLK_W / BYTE_W;
   localparam int NC = NB / 4;

   if (NB != 16) begin : g_bad_blk
      $error("aes_ks_round: block must be 16 bytes");
   end

   logic [7:0] sub_b [NB];
   logic [7:0] shf_b [NB];
   logic [7:0] mix_b [NB];

   for (genvar n = 0; n < NB; n++) begin : g_sub
      assign sub_b[n] = sbox(state_i[BLK_W-1-BYTE_W*n -: BYTE_W]);
   end

   // row r of column c takes row r of column (c+r) mod 4
   for (genvar c = 0; c < NC; c++) begin : g_col
      for (genvar r = 0; r < 4; r++) begin : g_row
         localparam int SRC = 4 * ((c + r) % 4) + r;
         assign shf_b[4*c+r] = shf_src(SRC);
      end
      logic [7:0] a0, a1, a2, a3;
      assign a0 = shf_b[4*c];
      assign a1 = shf_b[4*c+1];
      assign a2 = shf_b[4*c+2];
      assign a3 = shf_b[4*c+3];
      assign mix_b[4*c]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
      assign mix_b[4*c+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
      assign mix_b[4*c+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
      assign mix_b[4*c+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
   end

   function automatic logic [7:0] shf_src(input int idx);
      return sub_b[idx];
   endfunction

   for (genvar n = 0; n < NB; n++) begin : g_ark
      assign state_o[BLK_W-1-BYTE_W*n -: BYTE_W] =
         (last_i ? shf_b[n] : mix_b[n]) ^ rkey_i[BLK_W-1-BYTE_W*n -: BYTE_W];
   end

endmodule

// File: rtl/aes_ks_keystep.sv
`timescale 1ns/1ps
module aes_ks_keystep
   import aes_ks_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int WIN    = 8,
   parameter int STEP   = 4,
   parameter int CNT_W  = 4
) (
   input  logic [WIN*WORD_W-1:0]  win_i,
   input  logic [CNT_W-1:0]       nk_i,
   input  logic [CNT_W-1:0]       pos_i,
   input  logic [7:0]             rc_i,
   output logic [WIN*WORD_W-1:0]  win_o,
   output logic [CNT_W-1:0]       pos_o,
   output logic [7:0]             rc_o,
   output logic [STEP*WORD_W-1:0] rkey_o
);

   localparam int SEQ = WIN + STEP;

   if (WORD_W != 32 || WIN != 8 || STEP != 4) begin : g_bad_cfg
      $error("aes_ks_keystep: unsupported geometry");
   end

   logic [WORD_W-1:0] seq [SEQ];
   logic [WORD_W-1:0] prev;
   logic [WORD_W-1:0] far;
   logic [WORD_W-1:0] tmp;
   logic [CNT_W-1:0]  pos;
   logic [7:0]        rc;

   // seq[0] is the oldest window word; seq[WIN+t] is the t-th new word
   always_comb begin
      for (int k = 0; k < WIN; k++) seq[k] = win_i[k*WORD_W +: WORD_W];
      for (int k = WIN; k < SEQ; k++) seq[k] = '0;
      pos  = pos_i;
      rc   = rc_i;
      prev = '0;
      far  = '0;
      tmp  = '0;
      for (int t = 0; t < STEP; t++) begin
         prev = seq[WIN-1+t];
         case (nk_i)
            4'd8:    far = seq[t];
            4'd6:    far = seq[t+2];
            default: far = seq[t+4];
         endcase
         if (pos == '0) begin
            tmp = sub_word(rot_word(prev)) ^ {rc, 24'h000000};
            rc  = xt(rc);
         end else if (nk_i == 4'd8 && pos == 4'd4) begin
            tmp = sub_word(prev);
         end else begin
            tmp = prev;
         end
         seq[WIN+t] = far ^ tmp;
         pos = (pos == nk_i - 4'd1) ? '0 : pos + 4'd1;
      end
      for (int k = 0; k < WIN; k++) win_o[k*WORD_W +: WORD_W] = seq[k+STEP];
      pos_o = pos;
      rc_o  = rc;
      case (nk_i)
         4'd8:    rkey_o = {seq[4], seq[5], seq[6], seq[7]};
         4'd6:    rkey_o = {seq[6], seq[7], seq[8], seq[9]};
         default: rkey_o = {seq[8], seq[9], seq[10], seq[11]};
      endcase
   end

endmodule

// File: rtl/aes_ks_core.sv
`timescale 1ns/1ps
module aes_ks_core
   import aes_ks_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int BLK_W   = 128,
   parameter int MAX_NK  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [1:0]                key_sel_i,
   input  logic [WORD_W-1:0]         key_word_i,
   input  logic [$clog2(MAX_NK)-1:0] key_idx_i,
   input  logic                      key_load_i,
   input  logic [BLK_W-1:0]          data_i,
   input  logic                      start_i,
   output logic [BLK_W-1:0]          data_o,
   output logic                      done_o
);

   localparam int IDX_W = $clog2(MAX_NK);
   localparam int WIN_W = MAX_NK * WORD_W;
   localparam int CNT_W = 4;
   localparam int NBW   = BLK_W / WORD_W;

   if (WORD_W != 32 || BLK_W != 4 * WORD_W || MAX_NK != 8) begin : g_bad_cfg
      $error("aes_ks_core: supports 32-bit words, 128-bit blocks, 8 key slots");
   end

   logic [WORD_W-1:0] key_q [MAX_NK];
   logic [CNT_W-1:0]  nk_sel, nr_sel;
   logic [CNT_W-1:0]  nk_q, nr_q, rnd_q, pos_q, pos_d;
   logic [7:0]        rc_q, rc_d;
   logic [WIN_W-1:0]  win_q, win_d, win_init;
   logic [BLK_W-1:0]  state_q, state_d, rk0, rk_d;
   logic              busy_q, done_q, last, start_go;

   always_comb begin
      case (key_sel_i)
         2'd1:    begin nk_sel = 4'd6; nr_sel = 4'd12; end
         2'd2:    begin nk_sel = 4'd8; nr_sel = 4'd14; end
         default: begin nk_sel = 4'd4; nr_sel = 4'd10; end
      endcase
   end

   assign start_go = start_i & ~busy_q;
   assign last     = busy_q & (rnd_q == nr_q);

   // key store
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int j = 0; j < MAX_NK; j++) key_q[j] <= '0;
      end else if (key_load_i) begin
         key_q[key_idx_i] <= key_word_i;
      end
   end

   // first round key and initial schedule window (key right-aligned)
   always_comb begin
      rk0 = '0;
      for (int j = 0; j < NBW; j++) rk0[BLK_W-1-j*WORD_W -: WORD_W] = key_q[j];
      win_init = '0;
      for (int j = 0; j < MAX_NK; j++) begin
         if (j < int'(nk_sel))
            win_init[(MAX_NK - int'(nk_sel) + j)*WORD_W +: WORD_W] = key_q[j];
      end
   end

   aes_ks_keystep #(
      .WORD_W (WORD_W),
      .WIN    (MAX_NK),
      .STEP   (NBW),
      .CNT_W  (CNT_W)
   ) u_keystep (
      .win_i  (win_q),
      .nk_i   (nk_q),
      .pos_i  (pos_q),
      .rc_i   (rc_q),
      .win_o  (win_d),
      .pos_o  (pos_d),
      .rc_o   (rc_d),
      .rkey_o (rk_d)
   );

   aes_ks_round #(
      .BLK_W (BLK_W)
   ) u_round (
      .state_i (state_q),
      .rkey_i  (rk_d),
      .last_i  (last),
      .state_o (state_d)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= '0;
         win_q   <= '0;
         nk_q    <= 4'd4;
         nr_q    <= 4'd10;
         rnd_q   <= '0;
         pos_q   <= '0;
         rc_q    <= 8'h01;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last;
         if (start_go) begin
            state_q <= data_i ^ rk0;
            win_q   <= win_init;
            nk_q    <= nk_sel;
            nr_q    <= nr_sel;
            pos_q   <= '0;
            rc_q    <= 8'h01;
            rnd_q   <= 4'd1;
            busy_q  <= 1'b1;
         end else if (busy_q) begin
            state_q <= state_d;
            win_q   <= win_d;
            pos_q   <= pos_d;
            rc_q    <= rc_d;
            rnd_q   <= rnd_q + 4'd1;
            if (last) busy_q <= 1'b0;
         end
      end
   end

   assign done_o = done_q;

   if (OUT_REG) begin : g_out_reg
      logic [BLK_W-1:0] dout_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)   dout_q <= '0;
         else if (last) dout_q <= state_d;
      end
      assign data_o = dout_q;

      // R9
      out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !$stable(data_o) |-> done_o);
   end else begin : g_out_state
      assign data_o = state_q;
   end

   // R6
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R6
   round_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |-> (rnd_q >= 4'd1 && rnd_q <= nr_q));

   // R7
   busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && start_i && rnd_q != nr_q) |=> (busy_q && rnd_q == $past(rnd_q) + 4'd1));

   // R8
   cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && rnd_q != nr_q) |=> ($stable(nk_q) && $stable(nr_q)));

   // R4
   sel3_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_q && key_sel_i == 2'd3) |=> (nk_q == 4'd4 && nr_q == 4'd10));

   // R2
   sched_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |-> (pos_q < nk_q));

endmodule

// File: tb/aes_ks_core_tb.sv
`timescale 1ns/1ps
module aes_ks_core_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   key_sel = 2'd0;
   logic [31:0]  key_word = '0;
   logic [2:0]   key_idx = '0;
   logic         key_load = 1'b0;
   logic [127:0] din = '0;
   logic         start = 1'b0;
   logic [127:0] dout;
   logic         done;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   aes_ks_core u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .key_sel_i  (key_sel),
      .key_word_i (key_word),
      .key_idx_i  (key_idx),
      .key_load_i (key_load),
      .data_i     (din),
      .start_i    (start),
      .data_o     (dout),
      .done_o     (done)
   );

   localparam logic [255:0] K_SEQ  = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
   localparam logic [255:0] K_128B = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
   localparam logic [255:0] K_192B = {192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'h0};
   localparam logic [255:0] K_256B = 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;
   localparam logic [127:0] P_A = 128'h00112233445566778899aabbccddeeff;
   localparam logic [127:0] P_B = 128'h3243f6a8885a308d313198a2e0370734;
   localparam logic [127:0] P_C = 128'h6bc1bee22e409f96e93d7e117393172a;

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic load_key(input logic [255:0] k, input int nw);
      for (int j = 0; j < nw; j++) begin
         @(negedge clk);
         key_load = 1'b1;
         key_idx  = j[2:0];
         key_word = k[255-32*j -: 32];
      end
      @(negedge clk);
      key_load = 1'b0;
   endtask

   // start one block; wait for done, measuring edges since the start edge
   task automatic run_block(input logic [1:0] sel, input logic [127:0] pt,
                            output logic [127:0] res, output int lat);
      @(negedge clk);
      key_sel = sel;
      din     = pt;
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      res = dout;
   endtask

   task automatic vec(input string tag, input logic [255:0] k, input int nw, input logic [1:0] sel,
                      input logic [127:0] pt, input logic [127:0] exp, input int nr);
      logic [127:0] res;
      int lat;
      load_key(k, nw);
      run_block(sel, pt, res, lat);
      chk(res == exp, {tag, " ciphertext"}, res, exp);
      chk(lat == nr, "R6 latency", 128'(lat), 128'(nr));
      @(negedge clk);
      chk(done == 1'b0, "R6 done single cycle", 128'(done), 128'd0);
   endtask

   task automatic t_reset();
      chk(done == 1'b0, "R10 done after reset", 128'(done), 128'd0);
      chk(dout == '0, "R10 data after reset", dout, 128'd0);
   endtask

   task automatic t_key128();
      vec("R1 R5 seq key", K_SEQ, 4, 2'd0, P_A, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 10);
      vec("R1 alt key", K_128B, 4, 2'd0, P_B, 128'h3925841d02dc09fbdc118597196a0b32, 10);
      vec("R1 alt pt", K_128B, 4, 2'd0, P_C, 128'h3ad77bb40d7a3660a89ecaf32466ef97, 10);
   endtask

   task automatic t_key192();
      vec("R2 seq key", K_SEQ, 6, 2'd1, P_A, 128'hdda97ca4864cdfe06eaf70a0ec0d7191, 12);
      vec("R2 alt key", K_192B, 6, 2'd1, P_C, 128'hbd334f1d6e45f25ff712a214571fa5cc, 12);
   endtask

   task automatic t_key256();
      vec("R3 seq key", K_SEQ, 8, 2'd2, P_A, 128'h8ea2b7ca516745bfeafc49904b496089, 14);
      vec("R3 alt key", K_256B, 8, 2'd2, P_C, 128'hf3eed1bdb5d2a03c064b5a7e3db181f8, 14);
   endtask

   task automatic t_sel3();
      // slots 4..7 still hold the 256-bit key; code 3 must ignore them
      vec("R4 code 3", K_128B, 4, 2'd3, P_B, 128'h3925841d02dc09fbdc118597196a0b32, 10);
   endtask

   task automatic t_busy_start();
      int lat;
      int extra;
      load_key(K_SEQ, 4);
      @(negedge clk);
      key_sel = 2'd0; din = P_A; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      repeat (3) begin @(negedge clk); lat++; end
      din = P_B; start = 1'b1;
      @(negedge clk);
      lat++;
      start = 1'b0;
      while (!done && lat < 40) begin @(negedge clk); lat++; end
      chk(lat == 10, "R7 latency with stray start", 128'(lat), 128'd10);
      chk(dout == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R7 result with stray start",
          dout, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
      extra = 0;
      repeat (20) begin @(negedge clk); if (done) extra++; end
      chk(extra == 0, "R7 no extra done", 128'(extra), 128'd0);
   endtask

   task automatic t_key_change();
      int lat;
      load_key(K_SEQ, 8);
      @(negedge clk);
      key_sel = 2'd2; din = P_A; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      key_sel = 2'd0;
      lat = 0;
      for (int j = 0; j < 8; j++) begin
         key_load = 1'b1; key_idx = j[2:0]; key_word = 32'hdeadbeef ^ j;
         @(negedge clk);
         lat++;
      end
      key_load = 1'b0;
      while (!done && lat < 40) begin @(negedge clk); lat++; end
      chk(lat == 14, "R8 latency after select change", 128'(lat), 128'd14);
      chk(dout == 128'h8ea2b7ca516745bfeafc49904b496089, "R8 result after key rewrite",
          dout, 128'h8ea2b7ca516745bfeafc49904b496089);
   endtask

   task automatic t_hold();
      logic [127:0] res;
      int lat;
      load_key(K_128B, 4);
      run_block(2'd0, P_C, res, lat);
      din = P_A;
      repeat (6) @(negedge clk);
      chk(dout == res, "R9 output held", dout, res);
      chk(done == 1'b0, "R9 done stays low", 128'(done), 128'd0);
   endtask

   task automatic t_back2back();
      logic [127:0] res;
      int lat;
      load_key(K_128B, 4);
      run_block(2'd0, P_B, res, lat);
      chk(res == 128'h3925841d02dc09fbdc118597196a0b32, "R11 first block", res,
          128'h3925841d02dc09fbdc118597196a0b32);
      // still in the done cycle: raise start now
      din = P_C; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 40) begin @(negedge clk); lat++; end
      chk(lat == 10, "R11 back-to-back latency", 128'(lat), 128'd10);
      chk(dout == 128'h3ad77bb40d7a3660a89ecaf32466ef97, "R11 back-to-back result", dout,
          128'h3ad77bb40d7a3660a89ecaf32466ef97);
   endtask

   initial begin
      #(8 * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_key128();
      t_key192();
      t_key256();
      t_sel3();
      t_busy_start();
      t_key_change();
      t_hold();
      t_back2back();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule